// File: doc/BRIEF.md
# Bidirectional Gate-Scan Shift Register

This block is the digital core of a row scan driver for an active-matrix display. A chain of per-row stages moves a scan token one row per rising edge of the row clock. A direction input chooses which end of the chain takes serial data and which end hands the token on to the next cascaded driver. A two-bit span select sets how many rows are live. In the two reduced spans a fixed run of middle rows drops out of the chain: the chain jumps straight over it, and those rows stay inactive.

Each row has a one-bit drive code: 1 selects the high rail and 0 the low rail. A blanking input holds every live row low. An active-low panel-on input forces every live row high, and while it is low the chain is cleared on each rising edge. Both inputs act without reference to the row clock. Bypassed rows stay low whatever the other inputs do. The cascade output is taken from the last live stage and is registered on the falling edge of the row clock.

Top module: `gate_scan_core`

## Requirements
- R1: With dir_i = 1, ser_lo_i is sampled into row 1 (gate_o[0]) on a rising edge, and on each rising edge every live row takes the value of the live row below it.
- R2: With dir_i = 0, ser_hi_i is sampled into the highest row (gate_o[N_CH-1]), and the token moves toward row 1 one live row per rising edge.
- R3: The cascade output holds the content of the last live stage (the top row when dir_i = 1, row 1 when dir_i = 0) as registered on the falling edge, and it never changes at a rising edge. It appears on end_hi_o with end_hi_oe_o = 1 when dir_i = 1, and on end_lo_o with end_lo_oe_o = 1 when dir_i = 0. The idle end reads 0 with its enable at 0.
- R4: With mode_i = 2'b10, rows 133 to 169 are left out of the chain, so row 132 feeds row 170 (and row 170 feeds row 132 in reverse), giving 263 live rows.
- R5: With mode_i = 2'b01, rows 129 to 172 are left out of the chain, so rows 128 and 173 are joined, giving 256 live rows.
- R6: A bypassed row always drives 0, whatever the stage data, blank_i or disp_on_n_i.
- R7: While blank_i = 1 and disp_on_n_i = 1, every row drives 0, with no clock edge needed.
- R8: While disp_on_n_i = 0, every live row drives 1 with no clock edge needed, and this has priority over blank_i.
- R9: A rising edge seen with disp_on_n_i = 0 clears every stage.
- R10: mode_i = 2'b00 gives the full 300-row chain and sets mode_error_o = 1. mode_error_o is 0 in the other spans.
- R11: While rst_n_i = 0, all stages and the cascade register are 0, so gate_o, end_lo_o and end_hi_o read 0.
- R12: A single 1 sampled on a rising edge shows on the first live row right after that edge. It reaches the cascade output at the K-th falling edge counted from that one, where K is the live row count (300, 263 or 256).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Row shift clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| dir_i | input | 1 | 1: scan from row 1 upward, 0: scan from the top row downward |
| mode_i | input | 2 | Span select: 11 full, 10 263 rows, 01 256 rows, 00 illegal |
| ser_lo_i | input | 1 | Serial data at the row-1 end (used when dir_i = 1) |
| ser_hi_i | input | 1 | Serial data at the top-row end (used when dir_i = 0) |
| blank_i | input | 1 | Asynchronous blank, forces live rows low |
| disp_on_n_i | input | 1 | Asynchronous active-low panel-on, forces live rows high |
| gate_o | output | N_CH | Per-row drive code, bit i is row i+1 |
| end_lo_o | output | 1 | Cascade data at the row-1 end |
| end_lo_oe_o | output | 1 | 1 when the row-1 end is driving |
| end_hi_o | output | 1 | Cascade data at the top-row end |
| end_hi_oe_o | output | 1 | 1 when the top-row end is driving |
| mode_error_o | output | 1 | Illegal span select seen |

## Verification
The bench builds the block with its default parameters: 300 rows and the two bypass runs at rows 133 to 169 and 129 to 172. At these values every span walks a lone token through its whole length in a few hundred cycles. The row pairs on each side of each bypass run, the jump across the run, and the exact falling edge on which the token leaves the chain are all observed in both directions. The random phase changes span and direction while data sits in the chain. This catches stale bits left in rows that become bypassed.

// File: rtl/gsr_pkg.sv
package gsr_pkg;

  typedef enum logic [1:0] {
    SPAN_BAD  = 2'b00,
    SPAN_B    = 2'b01,
    SPAN_A    = 2'b10,
    SPAN_FULL = 2'b11
  } span_e;

  // row numbers are 1-based; returns 1 when the row takes part in the chain
  function automatic logic row_live(input int row, input span_e span,
                                    input int a_first, input int a_last,
                                    input int b_first, input int b_last);
    logic live;
    live = 1'b1;
    if (span == SPAN_A && row >= a_first && row <= a_last) live = 1'b0;
    if (span == SPAN_B && row >= b_first && row <= b_last) live = 1'b0;
    return live;
  endfunction

endpackage

// File: rtl/gsr_rst_sync.sv
module gsr_rst_sync (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/gsr_span.sv
module gsr_span
  import gsr_pkg::*;
#(
  parameter int N_CH    = 300,
  parameter int A_FIRST = 133,
  parameter int A_LAST  = 169,
  parameter int B_FIRST = 129,
  parameter int B_LAST  = 172
) (
  input  logic [1:0]      mode_i,
  output span_e           span_o,
  output logic [N_CH-1:0] live_o,
  output logic            bad_o
);

  always_comb begin
    bad_o  = (mode_i == 2'b00);
    span_o = bad_o ? SPAN_FULL : span_e'(mode_i);
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_live
    assign live_o[g] = row_live(g + 1, span_o, A_FIRST, A_LAST, B_FIRST, B_LAST);
  end

endmodule

// File: rtl/gsr_chain.sv
module gsr_chain
  import gsr_pkg::*;
#(
  parameter int N_CH    = 300,
  parameter int A_FIRST = 133,
  parameter int A_LAST  = 169,
  parameter int B_FIRST = 129,
  parameter int B_LAST  = 172
) (
  input  logic            clk_i,
  input  logic            rst_n_i,
  input  logic            dir_i,
  input  span_e           span_i,
  input  logic [N_CH-1:0] live_i,
  input  logic            ser_lo_i,
  input  logic            ser_hi_i,
  input  logic            clear_i,
  output logic [N_CH-1:0] stage_o
);

  // 0-based indices of the stages that border each bypass run
  localparam int A_BELOW = A_FIRST - 2;
  localparam int A_ABOVE = A_LAST;
  localparam int B_BELOW = B_FIRST - 2;
  localparam int B_ABOVE = B_LAST;

  logic [N_CH-1:0] stage_q;
  logic [N_CH-1:0] stage_d;
  logic            jump_up;
  logic            jump_dn;

  // value that crosses the bypass run in each direction
  always_comb begin
    jump_up = (span_i == SPAN_A) ? stage_q[A_BELOW] : stage_q[B_BELOW];
    jump_dn = (span_i == SPAN_A) ? stage_q[A_ABOVE] : stage_q[B_ABOVE];
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_stage
    logic from_below;
    logic from_above;

    if (g == 0) begin : g_first
      assign from_below = ser_lo_i;
    end else begin : g_mid_lo
      assign from_below = live_i[g-1] ? stage_q[g-1] : jump_up;
    end

    if (g == N_CH - 1) begin : g_last
      assign from_above = ser_hi_i;
    end else begin : g_mid_hi
      assign from_above = live_i[g+1] ? stage_q[g+1] : jump_dn;
    end

    always_comb begin
      if (clear_i || !live_i[g]) stage_d[g] = 1'b0;
      else if (dir_i)            stage_d[g] = from_below;
      else                       stage_d[g] = from_above;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) stage_q <= '0;
    else          stage_q <= stage_d;
  end

  assign stage_o = stage_q;

endmodule

// File: rtl/gsr_cascade.sv
module gsr_cascade #(
  parameter int N_CH = 300
) (
  input  logic            clk_i,
  input  logic            rst_n_i,
  input  logic            dir_i,
  input  logic [N_CH-1:0] stage_i,
  output logic            end_lo_o,
  output logic            end_lo_oe_o,
  output logic            end_hi_o,
  output logic            end_hi_oe_o
);

  logic tail_d;
  logic tail_q;

  // both ends of the chain are always live stages
  always_comb tail_d = dir_i ? stage_i[N_CH-1] : stage_i[0];

  always_ff @(negedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) tail_q <= 1'b0;
    else          tail_q <= tail_d;
  end

  always_comb begin
    end_hi_oe_o = dir_i;
    end_lo_oe_o = !dir_i;
    end_hi_o    = dir_i & tail_q;
    end_lo_o    = !dir_i & tail_q;
  end

endmodule

// File: rtl/gsr_drive.sv
module gsr_drive #(
  parameter int N_CH = 300
) (
  input  logic [N_CH-1:0] stage_i,
  input  logic [N_CH-1:0] live_i,
  input  logic            blank_i,
  input  logic            disp_on_n_i,
  output logic [N_CH-1:0] gate_o
);

  // priority: bypass low, panel-on high, blank low, stage data
  for (genvar g = 0; g < N_CH; g++) begin : g_row
    always_comb begin
      if (!live_i[g])       gate_o[g] = 1'b0;
      else if (!disp_on_n_i) gate_o[g] = 1'b1;
      else if (blank_i)     gate_o[g] = 1'b0;
      else                  gate_o[g] = stage_i[g];
    end
  end

endmodule

// File: rtl/gate_scan_core.sv
module gate_scan_core
  import gsr_pkg::*;
#(
  parameter int N_CH    = 300,
  parameter int A_FIRST = 133,
  parameter int A_LAST  = 169,
  parameter int B_FIRST = 129,
  parameter int B_LAST  = 172
) (
  input  logic            clk_i,
  input  logic            rst_n_i,
  input  logic            dir_i,
  input  logic [1:0]      mode_i,
  input  logic            ser_lo_i,
  input  logic            ser_hi_i,
  input  logic            blank_i,
  input  logic            disp_on_n_i,
  output logic [N_CH-1:0] gate_o,
  output logic            end_lo_o,
  output logic            end_lo_oe_o,
  output logic            end_hi_o,
  output logic            end_hi_oe_o,
  output logic            mode_error_o
);

  logic            rst_n_q;
  span_e           span;
  logic [N_CH-1:0] live;
  logic [N_CH-1:0] stage;

  gsr_rst_sync u_rst (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_n_q)
  );

  gsr_span #(
    .N_CH(N_CH), .A_FIRST(A_FIRST), .A_LAST(A_LAST),
    .B_FIRST(B_FIRST), .B_LAST(B_LAST)
  ) u_span (
    .mode_i (mode_i),
    .span_o (span),
    .live_o (live),
    .bad_o  (mode_error_o)
  );

  gsr_chain #(
    .N_CH(N_CH), .A_FIRST(A_FIRST), .A_LAST(A_LAST),
    .B_FIRST(B_FIRST), .B_LAST(B_LAST)
  ) u_chain (
    .clk_i    (clk_i),
    .rst_n_i  (rst_n_q),
    .dir_i    (dir_i),
    .span_i   (span),
    .live_i   (live),
    .ser_lo_i (ser_lo_i),
    .ser_hi_i (ser_hi_i),
    .clear_i  (!disp_on_n_i),
    .stage_o  (stage)
  );

  gsr_cascade #(.N_CH(N_CH)) u_casc (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n_q),
    .dir_i       (dir_i),
    .stage_i     (stage),
    .end_lo_o    (end_lo_o),
    .end_lo_oe_o (end_lo_oe_o),
    .end_hi_o    (end_hi_o),
    .end_hi_oe_o (end_hi_oe_o)
  );

  gsr_drive #(.N_CH(N_CH)) u_drive (
    .stage_i     (stage),
    .live_i      (live),
    .blank_i     (blank_i),
    .disp_on_n_i (disp_on_n_i),
    .gate_o      (gate_o)
  );

endmodule

// File: rtl/gsr_checker.sv
module gsr_checker #(
  parameter int N_CH = 300
) (
  input logic            clk_i,
  input logic            rst_n_i,
  input logic            dir_i,
  input logic [1:0]      mode_i,
  input logic            blank_i,
  input logic            disp_on_n_i,
  input logic [N_CH-1:0] gate_o,
  input logic [N_CH-1:0] live,
  input logic            mode_error_o
);

  // R6: rows outside the chain never drive high
  a_r6_bypass_low: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (gate_o & ~live) == '0);

  // R8: panel-on forces all live rows high
  a_r8_panel_on_high: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !disp_on_n_i |-> (gate_o & live) == live);

  // R7: blank holds everything low
  a_r7_blank_low: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (disp_on_n_i && blank_i) |-> gate_o == '0);

  // R9: chain is empty after an edge seen with panel-on low
  a_r9_cleared: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !disp_on_n_i ##1 (disp_on_n_i && !blank_i) |-> gate_o == '0);

  // R1: one-row step upward in the full span
  a_r1_step_up: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (dir_i && $past(dir_i) && mode_i == 2'b11 && $past(mode_i) == 2'b11 &&
     disp_on_n_i && $past(disp_on_n_i) && !blank_i && !$past(blank_i))
    |-> gate_o[1] == $past(gate_o[0]));

  // R2: one-row step downward in the full span
  a_r2_step_down: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!dir_i && !$past(dir_i) && mode_i == 2'b11 && $past(mode_i) == 2'b11 &&
     disp_on_n_i && $past(disp_on_n_i) && !blank_i && !$past(blank_i))
    |-> gate_o[N_CH-2] == $past(gate_o[N_CH-1]));

  // R10: illegal span runs the full chain and is flagged
  a_r10_bad_span: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    mode_i == 2'b00 |-> (mode_error_o && (&live)));

endmodule

bind gate_scan_core gsr_checker #(.N_CH(N_CH)) u_gsr_checker (
  .clk_i        (clk_i),
  .rst_n_i      (rst_n_i),
  .dir_i        (dir_i),
  .mode_i       (mode_i),
  .blank_i      (blank_i),
  .disp_on_n_i  (disp_on_n_i),
  .gate_o       (gate_o),
  .live         (live),
  .mode_error_o (mode_error_o)
);

// File: tb/test_gate_scan_core.sv
`timescale 1ns/1ps
module test_gate_scan_core;

  localparam int N = 300;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         dir;
  logic [1:0]   mode;
  logic         ser_lo, ser_hi, blank, don_n;
  logic [N-1:0] gate;
  logic         end_lo, end_lo_oe, end_hi, end_hi_oe, merr;

  int checks = 0;
  int fails  = 0;

  logic [N-1:0] st;      // model of the chain
  logic         tail_m;  // model of the cascade register

  always #4 clk = ~clk;

  gate_scan_core i_gate_scan_core (
    .clk_i(clk), .rst_n_i(rst_n), .dir_i(dir), .mode_i(mode),
    .ser_lo_i(ser_lo), .ser_hi_i(ser_hi), .blank_i(blank), .disp_on_n_i(don_n),
    .gate_o(gate), .end_lo_o(end_lo), .end_lo_oe_o(end_lo_oe),
    .end_hi_o(end_hi), .end_hi_oe_o(end_hi_oe), .mode_error_o(merr)
  );

  function automatic logic in_chain(input int row, input logic [1:0] m);
    if (m == 2'b10) return !(row >= 133 && row <= 169);
    if (m == 2'b01) return !(row >= 129 && row <= 172);
    return 1'b1;
  endfunction

  function automatic int live_count(input logic [1:0] m);
    if (m == 2'b10) return 263;
    if (m == 2'b01) return 256;
    return 300;
  endfunction

  function automatic logic [N-1:0] exp_gate();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++)
      v[i] = in_chain(i + 1, mode) & (!don_n | (!blank & st[i]));
    return v;
  endfunction

  // model of one rising edge, using a scan-order list of live rows
  task automatic model_edge();
    int ord[N];
    int k;
    logic [N-1:0] nx;
    k = 0;
    for (int i = 0; i < N; i++) begin
      int idx;
      idx = dir ? i : N - 1 - i;
      if (in_chain(idx + 1, mode)) begin ord[k] = idx; k++; end
    end
    nx = '0;
    if (rst_n && don_n) begin
      for (int j = 0; j < k; j++)
        nx[ord[j]] = (j == 0) ? (dir ? ser_lo : ser_hi) : st[ord[j-1]];
    end
    st = nx;
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_ends(input string req);
    check_bit(req, end_hi, dir & tail_m);
    check_bit(req, end_lo, !dir & tail_m);
    check_bit(req, end_hi_oe, dir);
    check_bit(req, end_lo_oe, !dir);
  endtask

  // one clock: model edge, drive new inputs, check rows, then check the cascade
  task automatic step(input string req, input logic n_dir, input logic [1:0] n_mode,
                      input logic n_din, input logic n_blank, input logic n_don_n);
    logic [N-1:0] e;
    @(posedge clk);
    model_edge();
    #1;
    dir = n_dir; mode = n_mode; blank = n_blank; don_n = n_don_n;
    ser_lo = n_dir ? n_din : 1'b0;
    ser_hi = n_dir ? 1'b0 : n_din;
    #2;
    e = exp_gate();
    checks++;
    if (gate !== e) begin
      fails++;
      $display("FAIL %s gate actual=%h expected=%h t=%0t", req, gate, e, $time);
    end
    check_ends("R3 no change at rising edge");
    check_bit("R10 mode_error", merr, mode == 2'b00);
    @(negedge clk);
    tail_m = rst_n ? (dir ? st[N-1] : st[0]) : 1'b0;
    #1;
    check_ends(req);
  endtask

  // walk a lone token through a span and measure its cascade latency
  task automatic walk(input string req, input logic d, input logic [1:0] m);
    int k, seen;
    int first;
    k = live_count(m);
    seen = -1;
    step(req, d, m, 1'b0, 1'b0, 1'b1);
    step(req, d, m, 1'b1, 1'b0, 1'b1);
    step(req, d, m, 1'b0, 1'b0, 1'b1);
    first = d ? 0 : N - 1;
    check_bit("R12 first row after sampling edge", gate[first], 1'b1);
    if (tail_m && seen < 0) seen = 1;
    for (int c = 2; c <= k + 3; c++) begin
      step(req, d, m, 1'b0, 1'b0, 1'b1);
      if (tail_m && seen < 0) seen = c;
    end
    checks++;
    if (seen != k) begin
      fails++;
      $display("FAIL R12 cascade falling edge actual=%0d expected=%0d", seen, k);
    end
  endtask

  initial begin
    int cyc;
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h1d5e_a7c3));
    rst_n = 1'b0; dir = 1'b1; mode = 2'b11; ser_lo = 1'b1; ser_hi = 1'b1;
    blank = 1'b0; don_n = 1'b1; st = '0; tail_m = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    checks++;
    if (gate !== '0) begin
      fails++;
      $display("FAIL R11 reset gate actual=%h expected=0", gate);
    end
    check_bit("R11 reset cascade", end_hi, 1'b0);
    @(posedge clk); #1;
    rst_n = 1'b1; ser_lo = 1'b0; ser_hi = 1'b0;
    for (int i = 0; i < 4; i++) step("R11 after reset", 1'b1, 2'b11, 1'b0, 1'b0, 1'b1);

    walk("R1 full up", 1'b1, 2'b11);
    walk("R2 full down", 1'b0, 2'b11);
    walk("R4 263 up", 1'b1, 2'b10);
    walk("R4 263 down", 1'b0, 2'b10);
    walk("R5 256 up", 1'b1, 2'b01);
    walk("R5 256 down", 1'b0, 2'b01);
    walk("R10 illegal span up", 1'b1, 2'b00);

    // R7 / R8 / R9 directed: fill, blank, panel-on, then check cleared
    for (int i = 0; i < 20; i++) step("R1 fill", 1'b1, 2'b11, 1'b1, 1'b0, 1'b1);
    step("R7 blank", 1'b1, 2'b11, 1'b0, 1'b1, 1'b1);
    step("R8 panel-on over blank", 1'b1, 2'b10, 1'b0, 1'b1, 1'b0);
    step("R9 cleared", 1'b1, 2'b11, 1'b0, 1'b0, 1'b1);
    checks++;
    if (gate !== '0) begin
      fails++;
      $display("FAIL R9 chain not cleared actual=%h expected=0", gate);
    end

    // R6: data in the middle rows, then shrink the span
    for (int i = 0; i < 160; i++) step("R6 fill", 1'b1, 2'b11, 1'b1, 1'b0, 1'b1);
    step("R6 shrink span", 1'b1, 2'b01, 1'b1, 1'b0, 1'b1);
    step("R6 bypass held", 1'b1, 2'b11, 1'b0, 1'b0, 1'b1);
    check_bit("R6 row 150 emptied", gate[149], 1'b0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] m;
      logic d;
      m = (($urandom % 50) == 0) ? 2'($urandom) : mode;
      d = (($urandom % 80) == 0) ? ~dir : dir;
      step("R1 R2 R4 R5 R6 R7 R8 random", d, m, 1'($urandom),
           ($urandom % 16) == 0, ($urandom % 40) != 0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule